// File: doc/BRIEF.md
# Multi-Source Chip Reset Hub

This block collects every reset request of a small microcontroller and turns them into one chip reset. The requests are an always-present power-on reset, a power-monitor reset, a watchdog timeout, a software request bit and an optional external active-low reset pin. Two non-volatile configuration inputs control the sources. The first decides whether the shared pin acts as a reset input or as a plain digital input. The second decides whether a watchdog timeout may reset the chip.

The power-on and power-monitor inputs assert the chip reset asynchronously. Every other source is sampled on the clock. Once the last asserting source has gone away, the reset is held for a further `STRETCH_CYCLES` clock cycles and then released on a clock edge. The block also keeps three pieces of state. The first is a sticky low-power memory-mode bit that only power-on reset clears. The second is the software reset bit. The third is a cause register that shows what started the last reset.

Top module: `chip_reset_hub`

## Requirements
- R1: While `por_i` is high, `chip_rst_o` is 1 without waiting for a clock edge. At the same time `cause_o` becomes 4'b0001, and `lp_mem_o` and `sw_rst_bit_o` become 0.
- R2: `chip_rst_o` becomes 1 on the first clock edge at which any synchronous request is sampled. It falls on the edge that comes exactly `STRETCH_CYCLES` (default 16) edges after the last edge at which any request was seen.
- R3: When `cfg_pin_gpio_i` is 0, the pin passes through a two-flop synchronizer. A low synchronized value is a reset request, so the reset stays on as long as the pin stays low.
- R4: When `cfg_pin_gpio_i` is 1, the pin never causes a reset and `pin_data_o` shows the synchronized pin value, which lags the pin by two edges. When `cfg_pin_gpio_i` is 0, `pin_data_o` reads 1.
- R5: A high `wdt_timeout_i` is a reset request only when `cfg_wdt_en_i` is 1. When `cfg_wdt_en_i` is 0, a timeout has no effect.
- R6: `sw_rst_set_i` sets `sw_rst_bit_o` on the next edge, but only while the chip reset is off. A set bit is a reset request. The bit clears itself on the edge after `chip_rst_o` is seen at 1.
- R7: `lp_set_i` sets `lp_mem_o`. After that, only `por_i` clears it. Pin, watchdog, software and power-monitor resets leave it at 1.
- R8: `pmon_rst_i` asserts `chip_rst_o` asynchronously and is stretched like any other source. It does not change `cause_o` or `lp_mem_o`.
- R9: The bits of `cause_o` are: bit0 power-on, bit1 pin, bit2 watchdog, bit3 software. At an edge where the reset is off and pin, watchdog or software requests are present, `cause_o` is loaded with exactly the set of those requests and bit0 is cleared. Requests that arrive while the reset is already on do not change `cause_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| pmon_rst_i | input | 1 | Power-monitor reset request, active high, asynchronous |
| cfg_pin_gpio_i | input | 1 | Pin role: 1 = digital input, 0 = active-low reset |
| cfg_wdt_en_i | input | 1 | 1 lets a watchdog timeout reset the chip |
| ext_pin_i | input | 1 | Raw shared pin |
| wdt_timeout_i | input | 1 | Watchdog timeout request |
| sw_rst_set_i | input | 1 | Software write of 1 to the reset bit |
| lp_set_i | input | 1 | Software set of the low-power memory bit |
| chip_rst_o | output | 1 | Combined chip reset, active high |
| pin_data_o | output | 1 | Synchronized pin value in digital-input mode |
| sw_rst_bit_o | output | 1 | Software reset bit |
| lp_mem_o | output | 1 | Sticky low-power memory-mode bit |
| cause_o | output | 4 | Cause of the last reset |

## Verification
Power-on and power-monitor resets must show on `chip_rst_o` in the same cycle, and the bench checks this one nanosecond after driving them, before any clock edge. A software set reaches the bit one edge later and the reset the edge after that. A falling pin reaches the reset three edges after it changes. Release comes `STRETCH_CYCLES` edges after the last request, and each of these delays takes one or more edges to appear. The bench therefore drives inputs on the falling edge and applies each rising edge to its own cycle model. It compares every output at the next falling edge, so each expected value is in its exact cycle.

// File: rtl/chip_reset_pkg.sv
package chip_reset_pkg;

    localparam int CAUSE_W = 4;

    typedef struct packed {
        logic sw;
        logic wdt;
        logic pin;
        logic por;
    } rst_cause_t;

    localparam rst_cause_t CAUSE_POWER_ON = '{sw: 1'b0, wdt: 1'b0, pin: 1'b0, por: 1'b1};

    function automatic rst_cause_t make_cause(input logic pin, input logic wdt, input logic sw);
        rst_cause_t c;
        c.sw  = sw;
        c.wdt = wdt;
        c.pin = pin;
        c.por = 1'b0;
        return c;
    endfunction

    function automatic logic any_sync_src(input logic pin, input logic wdt, input logic sw);
        return pin | wdt | sw;
    endfunction

endpackage

// File: rtl/crh_pin_sync.sv
module crh_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk_i or posedge arst_i) begin
                    if (arst_i) chain[0] <= RST_VAL;
                    else        chain[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or posedge arst_i) begin
                    if (arst_i) chain[i] <= RST_VAL;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/crh_stretch.sv
module crh_stretch #(
    parameter int CYCLES = 16
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic req_i,
    output logic rst_o
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST    = CW'(CYCLES);
    localparam logic [CW-1:0] PREV    = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            cnt   <= '0;
            rst_o <= 1'b1;
        end else if (req_i) begin
            cnt   <= '0;
            rst_o <= 1'b1;
        end else if (cnt != LAST) begin
            cnt   <= cnt + 1'b1;
            rst_o <= (cnt != PREV);
        end
    end
endmodule

// File: rtl/crh_state.sv
module crh_state
    import chip_reset_pkg::*;
(
    input  logic       clk_i,
    input  logic       por_i,
    input  logic       rst_now_i,
    input  logic       pin_req_i,
    input  logic       wdt_req_i,
    input  logic       sw_set_i,
    input  logic       lp_set_i,
    output logic       sw_bit_o,
    output logic       lp_o,
    output rst_cause_t cause_o
);
    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i)          sw_bit_o <= 1'b0;
        else if (rst_now_i) sw_bit_o <= 1'b0;
        else if (sw_set_i)  sw_bit_o <= 1'b1;
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i)         lp_o <= 1'b0;
        else if (lp_set_i) lp_o <= 1'b1;
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i)
            cause_o <= CAUSE_POWER_ON;
        else if (!rst_now_i && any_sync_src(pin_req_i, wdt_req_i, sw_bit_o))
            cause_o <= make_cause(pin_req_i, wdt_req_i, sw_bit_o);
    end
endmodule

// File: rtl/chip_reset_hub.sv
module chip_reset_hub
    import chip_reset_pkg::*;
#(
    parameter int STRETCH_CYCLES = 16,
    parameter int SYNC_STAGES    = 2
) (
    input  logic               clk_i,
    input  logic               por_i,
    input  logic               pmon_rst_i,
    input  logic               cfg_pin_gpio_i,
    input  logic               cfg_wdt_en_i,
    input  logic               ext_pin_i,
    input  logic               wdt_timeout_i,
    input  logic               sw_rst_set_i,
    input  logic               lp_set_i,
    output logic               chip_rst_o,
    output logic               pin_data_o,
    output logic               sw_rst_bit_o,
    output logic               lp_mem_o,
    output logic [CAUSE_W-1:0] cause_o
);
    logic       pin_sync;
    logic       pin_req;
    logic       wdt_req;
    logic       any_req;
    logic       hard_rst;
    rst_cause_t cause_q;

    crh_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk_i  (clk_i),
        .arst_i (por_i),
        .d_i    (ext_pin_i),
        .q_o    (pin_sync)
    );

    assign pin_req    = !cfg_pin_gpio_i && !pin_sync;
    assign wdt_req    = wdt_timeout_i && cfg_wdt_en_i;
    assign any_req    = pmon_rst_i | pin_req | wdt_req | sw_rst_bit_o;
    assign hard_rst   = por_i | pmon_rst_i;
    assign pin_data_o = cfg_pin_gpio_i ? pin_sync : 1'b1;

    crh_stretch #(.CYCLES(STRETCH_CYCLES)) u_stretch (
        .clk_i  (clk_i),
        .arst_i (hard_rst),
        .req_i  (any_req),
        .rst_o  (chip_rst_o)
    );

    crh_state u_state (
        .clk_i     (clk_i),
        .por_i     (por_i),
        .rst_now_i (chip_rst_o),
        .pin_req_i (pin_req),
        .wdt_req_i (wdt_req),
        .sw_set_i  (sw_rst_set_i),
        .lp_set_i  (lp_set_i),
        .sw_bit_o  (sw_rst_bit_o),
        .lp_o      (lp_mem_o),
        .cause_o   (cause_q)
    );

    assign cause_o = cause_q;
endmodule

// File: rtl/chip_reset_hub_chk.sv
module chip_reset_hub_chk (
    input logic       clk_i,
    input logic       por_i,
    input logic       pmon_rst_i,
    input logic       cfg_pin_gpio_i,
    input logic       cfg_wdt_en_i,
    input logic       pin_sync,
    input logic       chip_rst_o,
    input logic       sw_rst_bit_o,
    input logic       lp_mem_o,
    input logic [3:0] cause_o
);
    always @(posedge clk_i) begin
        if (por_i) begin
            p_por_forces_rst_r1: assert (chip_rst_o);
        end
    end

    p_pin_low_holds_r3: assert property (@(posedge clk_i) disable iff (por_i)
        (!cfg_pin_gpio_i && !pin_sync) |=> chip_rst_o);

    p_wdt_needs_enable_r5: assert property (@(posedge clk_i) disable iff (por_i)
        $rose(cause_o[2]) |-> $past(cfg_wdt_en_i));

    p_sw_self_clear_r6: assert property (@(posedge clk_i) disable iff (por_i)
        (sw_rst_bit_o && chip_rst_o) |=> !sw_rst_bit_o);

    p_lp_sticky_r7: assert property (@(posedge clk_i) disable iff (por_i)
        lp_mem_o |=> lp_mem_o);

    p_pmon_forces_rst_r8: assert property (@(posedge clk_i) disable iff (por_i)
        pmon_rst_i |-> chip_rst_o);
endmodule

bind chip_reset_hub chip_reset_hub_chk u_chk (
    .clk_i          (clk_i),
    .por_i          (por_i),
    .pmon_rst_i     (pmon_rst_i),
    .cfg_pin_gpio_i (cfg_pin_gpio_i),
    .cfg_wdt_en_i   (cfg_wdt_en_i),
    .pin_sync       (pin_sync),
    .chip_rst_o     (chip_rst_o),
    .sw_rst_bit_o   (sw_rst_bit_o),
    .lp_mem_o       (lp_mem_o),
    .cause_o        (cause_o)
);

// File: tb/chip_reset_hub_tb.sv
`timescale 1ns/1ps
module chip_reset_hub_tb;
    localparam int STRETCH = 16;

    logic clk = 1'b0;
    logic por = 1'b1, pmon = 1'b0, gpio = 1'b1, wen = 1'b0, pin = 1'b1;
    logic wdt = 1'b0, sws = 1'b0, lps = 1'b0;
    logic       rst_o, pdata_o, swbit_o, lp_o;
    logic [3:0] cause_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    chip_reset_hub #(.STRETCH_CYCLES(STRETCH)) u_dut (
        .clk_i          (clk),
        .por_i          (por),
        .pmon_rst_i     (pmon),
        .cfg_pin_gpio_i (gpio),
        .cfg_wdt_en_i   (wen),
        .ext_pin_i      (pin),
        .wdt_timeout_i  (wdt),
        .sw_rst_set_i   (sws),
        .lp_set_i       (lps),
        .chip_rst_o     (rst_o),
        .pin_data_o     (pdata_o),
        .sw_rst_bit_o   (swbit_o),
        .lp_mem_o       (lp_o),
        .cause_o        (cause_o)
    );

    // Cycle model built from the requirements
    logic       m_s1 = 1'b1, m_s2 = 1'b1, m_rst = 1'b1, m_lp = 1'b0, m_sw = 1'b0;
    logic [3:0] m_cause = 4'b0001;
    int         m_cnt = 0;

    always @(posedge clk) begin
        logic rst_eff, preq, wreq, req;
        if (por) begin
            m_s1 = 1'b1; m_s2 = 1'b1; m_rst = 1'b1; m_cnt = 0;
            m_lp = 1'b0; m_sw = 1'b0; m_cause = 4'b0001;
        end else begin
            rst_eff = m_rst | pmon;
            preq    = !gpio && !m_s2;
            wreq    = wdt && wen;
            req     = pmon | preq | wreq | m_sw;
            if (!rst_eff && (preq | wreq | m_sw)) m_cause = {m_sw, wreq, preq, 1'b0};
            if (rst_eff) m_sw = 1'b0;
            else if (sws) m_sw = 1'b1;
            if (lps) m_lp = 1'b1;
            if (req) begin
                m_cnt = 0; m_rst = 1'b1;
            end else if (m_cnt < STRETCH) begin
                m_cnt++;
                m_rst = (m_cnt != STRETCH);
            end
            m_s2 = m_s1;
            m_s1 = pin;
        end
    end

    function automatic logic exp_pdata(input logic g, input logic s2);
        return g ? s2 : 1'b1;
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 R3 R5 R6 R8 chip_rst", {3'b0, rst_o}, {3'b0, m_rst});
        chk("R4 pin_data", {3'b0, pdata_o}, {3'b0, exp_pdata(gpio, m_s2)});
        chk("R6 sw_bit", {3'b0, swbit_o}, {3'b0, m_sw});
        chk("R7 lp_bit", {3'b0, lp_o}, {3'b0, m_lp});
        chk("R9 cause", cause_o, m_cause);
    endtask

    task automatic cyc(input logic a_por, input logic a_pmon, input logic a_gpio, input logic a_wen,
                       input logic a_pin, input logic a_wdt, input logic a_sws, input logic a_lps);
        @(negedge clk);
        compare_all();
        por = a_por; pmon = a_pmon; gpio = a_gpio; wen = a_wen;
        pin = a_pin; wdt = a_wdt; sws = a_sws; lps = a_lps;
    endtask

    task automatic idle(input int n, input logic g, input logic p);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, g, wen, p, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        // R1: reset state under power-on
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        // R2: release after stretch
        idle(STRETCH + 3, 1'b1, 1'b1);
        // R7: set low-power bit, R6: software reset keeps it
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        idle(STRETCH + 5, 1'b1, 1'b1);
        // R5: watchdog disabled has no effect, then enabled
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        idle(3, 1'b1, 1'b1);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        idle(STRETCH + 3, 1'b1, 1'b1);
        // R4: pin low in gpio mode gives data, no reset
        idle(6, 1'b1, 1'b0);
        idle(3, 1'b1, 1'b1);
        // R3: pin as reset, held low for 10 cycles
        idle(3, 1'b0, 1'b1);
        idle(10, 1'b0, 1'b0);
        idle(STRETCH + 4, 1'b0, 1'b1);
        // R8: power monitor pulse, async check
        @(negedge clk);
        compare_all();
        pmon = 1'b1;
        #1;
        chk("R8 pmon async", {3'b0, rst_o}, 4'b0001);
        idle(2, 1'b0, 1'b1);
        idle(STRETCH + 3, 1'b0, 1'b1);
        // R1: power-on asserts asynchronously and clears lp
        @(negedge clk);
        compare_all();
        por = 1'b1;
        #1;
        chk("R1 por async", {3'b0, rst_o}, 4'b0001);
        chk("R1 lp cleared", {3'b0, lp_o}, 4'b0000);
        chk("R1 cause power-on", cause_o, 4'b0001);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        idle(STRETCH + 3, 1'b1, 1'b1);
        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic npin, ngpio, nwen;
            npin  = (($urandom % 20) == 0) ? ~pin : pin;
            ngpio = (($urandom % 120) == 0) ? ~gpio : gpio;
            nwen  = (($urandom % 90) == 0) ? ~wen : wen;
            cyc((($urandom % 500) == 0), (($urandom % 250) == 0), ngpio, nwen, npin,
                (($urandom % 60) == 0), (($urandom % 70) == 0), (($urandom % 150) == 0));
        end
        @(negedge clk);
        compare_all();
        finish_run();
    end
endmodule